// File: doc/BRIEF.md
# Quad Special-Wakeup Control Register Slave

This block is a small register slave that sits on a configuration bus and serves a cluster of four processor cores. Each access carries a 32-bit word index and 64 bits of data. The block keeps one special-wakeup request bit per core and one cluster-wide "done" flag. The request bits leave the block as outputs toward the power-management logic. The done flag can be read back through a status register.

The cores to be updated are chosen by a one-hot-or-more nibble inside the word index, not by the data. That nibble is removed before the index is compared, so one write can set or clear the request of any subset of the four cores at once. Any access that is not a full 8-byte access is rejected. Writes to indices the block does not implement raise a one-cycle strobe. Reads of such indices return all ones.

Top module: `qsw_wakeup_ctl`

## Requirements
- R1: After reset, all four wakeup requests, the done flag, `rsp_valid`, `unimp_wr` and `size_err` are 0.
- R2: Before decode, index bits 15..12 (LSB-0, the same as bits 16..19 counted from the MSB of the 32-bit index) are cleared. An index therefore matches a register whatever that nibble holds.
- R3: A full-size write whose masked index is 0x83c takes its set value from data bit 63 (LSB-0). From the next cycle, the done flag equals that value. All other data bits have no effect.
- R4: On that write, the wakeup request of core i (i = 0..3) takes the set value only if index bit 15-i (LSB-0) is 1. Unselected cores keep their value, and several cores may be written at once.
- R5: A full-size read returns `rsp_valid` = 1 with data one cycle after the request. For masked index 0x82c the data is 0x4800_0000_0000_0000 when done is 1 (LSB-0 bits 62 and 59), and 0 otherwise.
- R6: A full-size read of any other masked index returns 0xFFFF_FFFF_FFFF_FFFF.
- R7: A full-size write to any masked index other than 0x83c changes no state. It raises `unimp_wr` for exactly the one cycle after the request.
- R8: An access whose byte count is not 8 changes no state and raises `size_err` for one cycle. Such a read still answers, with all ones. It does not raise `unimp_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Word index, including the core-select nibble |
| req_bytes | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| wake_req | output | 4 | Per-core special-wakeup request, bit i = core i |
| wake_done | output | 1 | Cluster done flag |
| unimp_wr | output | 1 | One-cycle strobe for an unimplemented write |
| size_err | output | 1 | One-cycle strobe for a rejected access size |

## Verification
All results appear exactly one clock edge after the request. Wakeup bits and the done flag are registered state. The read data, its valid, and both strobes are registered responses. The bench drives each request on a falling edge and holds it through one rising edge. On the next falling edge it removes the request and samples all outputs in the same window. For the strobes, it also checks one cycle later that they have dropped. A model of the expected request vector and done flag is kept in the bench, so every state check compares all four cores, not only the cores that were selected.

// File: rtl/qsw_pkg.sv
package qsw_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_WAKE_WR  = 3'd1,
    OP_STAT_RD  = 3'd2,
    OP_OTHER_RD = 3'd3,
    OP_OTHER_WR = 3'd4,
    OP_BAD_SIZE = 3'd5
  } qsw_op_e;
endpackage

// File: rtl/qsw_decode.sv
module qsw_decode
  import qsw_pkg::*;
#(
  parameter int IDX_W     = 32,
  parameter int NUM_CORES = 4,
  parameter int SEL_POS   = 16,
  parameter int BYTES_W   = 4,
  parameter int ACC_BYTES = 8,
  parameter logic [IDX_W-1:0] WAKE_IDX = 32'h83c,
  parameter logic [IDX_W-1:0] STAT_IDX = 32'h82c
) (
  input  logic                 valid,
  input  logic                 write,
  input  logic [IDX_W-1:0]     index,
  input  logic [BYTES_W-1:0]   nbytes,
  output qsw_op_e              op,
  output logic [NUM_CORES-1:0] core_sel
);
  localparam int SEL_HI = IDX_W - 1 - SEL_POS;

  function automatic logic [IDX_W-1:0] sel_field_mask();
    logic [IDX_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CORES; i++) m[SEL_HI-i] = 1'b1;
    return m;
  endfunction

  function automatic logic [IDX_W-1:0] strip_sel(input logic [IDX_W-1:0] ix);
    return ix & ~sel_field_mask();
  endfunction

  logic [IDX_W-1:0] masked;
  logic             full_size;

  assign masked    = strip_sel(index);
  assign full_size = (nbytes == BYTES_W'(ACC_BYTES));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_sel
    assign core_sel[g] = index[SEL_HI-g];
  end

  always_comb begin
    op = OP_NONE;
    if (valid) begin
      if (!full_size)             op = OP_BAD_SIZE;
      else if (write)             op = (masked == WAKE_IDX) ? OP_WAKE_WR : OP_OTHER_WR;
      else                        op = (masked == STAT_IDX) ? OP_STAT_RD : OP_OTHER_RD;
    end
  end
endmodule

// File: rtl/qsw_wake_bank.sv
module qsw_wake_bank #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_CORES-1:0] sel,
  input  logic                 set_val,
  output logic [NUM_CORES-1:0] wake_q,
  output logic                 done_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     done_q <= 1'b0;
    else if (wr_en) done_q <= set_val;
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    always_ff @(posedge clk) begin
      if (!rst_n)              wake_q[g] <= 1'b0;
      else if (wr_en && sel[g]) wake_q[g] <= set_val;
    end

    AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sel[g]) |=> $stable(wake_q[g])); // R4
    AST_SEL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[g]) |=> (wake_q[g] == $past(set_val))); // R4
  end

  AST_DONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (done_q == $past(set_val))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(done_q) && $stable(wake_q))); // R7
endmodule

// File: rtl/qsw_resp.sv
module qsw_resp
  import qsw_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int DONE_B0  = 1,
  parameter int DONE_B1  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  qsw_op_e           op,
  input  logic              is_read,
  input  logic              done,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              unimp,
  output logic              size_err
);
  function automatic logic [DATA_W-1:0] status_word(input logic d);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DATA_W-1-DONE_B0] = d;
    w[DATA_W-1-DONE_B1] = d;
    return w;
  endfunction

  logic              rd_req;
  logic [DATA_W-1:0] rd_next;

  assign rd_req  = (op == OP_STAT_RD) || (op == OP_OTHER_RD) ||
                   ((op == OP_BAD_SIZE) && is_read);
  assign rd_next = (op == OP_STAT_RD) ? status_word(done) : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid   <= 1'b0;
      rdata    <= '0;
      unimp    <= 1'b0;
      size_err <= 1'b0;
    end else begin
      rvalid   <= rd_req;
      if (rd_req) rdata <= rd_next;
      unimp    <= (op == OP_OTHER_WR);
      size_err <= (op == OP_BAD_SIZE);
    end
  end

  AST_STAT_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STAT_RD) |=> (rvalid && (rdata == ($past(done) ? status_word(1'b1) : '0)))); // R5
  AST_OTHER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_OTHER_RD) |=> (rvalid && (&rdata))); // R6
  AST_UNIMP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    unimp |-> ($past(op) == OP_OTHER_WR)); // R7
  AST_SIZE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !unimp); // R8
endmodule

// File: rtl/qsw_wakeup_ctl.sv
module qsw_wakeup_ctl
  import qsw_pkg::*;
#(
  parameter int IDX_W     = 32,
  parameter int DATA_W    = 64,
  parameter int NUM_CORES = 4,
  parameter int SEL_POS   = 16,
  parameter int ACC_BYTES = 8,
  parameter logic [IDX_W-1:0] WAKE_IDX = 32'h83c,
  parameter logic [IDX_W-1:0] STAT_IDX = 32'h82c,
  localparam int BYTES_W  = $clog2(ACC_BYTES) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [IDX_W-1:0]     req_index,
  input  logic [BYTES_W-1:0]   req_bytes,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NUM_CORES-1:0] wake_req,
  output logic                 wake_done,
  output logic                 unimp_wr,
  output logic                 size_err
);
  qsw_op_e              dec_op;
  logic [NUM_CORES-1:0] dec_sel;
  logic                 wake_wr_ev;
  logic                 set_bit;

  qsw_decode #(
    .IDX_W(IDX_W), .NUM_CORES(NUM_CORES), .SEL_POS(SEL_POS),
    .BYTES_W(BYTES_W), .ACC_BYTES(ACC_BYTES),
    .WAKE_IDX(WAKE_IDX), .STAT_IDX(STAT_IDX)
  ) u_dec (
    .valid(req_valid), .write(req_write), .index(req_index),
    .nbytes(req_bytes), .op(dec_op), .core_sel(dec_sel)
  );

  assign wake_wr_ev = (dec_op == OP_WAKE_WR);
  assign set_bit    = req_wdata[DATA_W-1];

  qsw_wake_bank #(.NUM_CORES(NUM_CORES)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wake_wr_ev), .sel(dec_sel),
    .set_val(set_bit), .wake_q(wake_req), .done_q(wake_done)
  );

  qsw_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .op(dec_op), .is_read(!req_write),
    .done(wake_done), .rvalid(rsp_valid), .rdata(rsp_rdata),
    .unimp(unimp_wr), .size_err(size_err)
  );

  AST_BADSIZE_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_bytes != BYTES_W'(ACC_BYTES)) |=> ($stable(wake_req) && $stable(wake_done))); // R8
  AST_NIBBLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_bytes == BYTES_W'(ACC_BYTES) &&
     ((req_index & ~32'h0000_F000) == WAKE_IDX)) |=> (wake_done == $past(req_wdata[DATA_W-1]))); // R2
endmodule

// File: tb/qsw_wakeup_ctl_tb.sv
module qsw_wakeup_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_index = '0;
  logic [3:0]  req_bytes = 4'd8;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [3:0]  wake_req;
  logic        wake_done, unimp_wr, size_err;

  int n_run = 0, n_fail = 0;
  logic [3:0] m_wake = '0;
  logic       m_done = 1'b0;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] STAT_SET = 64'h4800_0000_0000_0000;

  always #5 clk = ~clk;

  qsw_wakeup_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wake_req(wake_req),
    .wake_done(wake_done), .unimp_wr(unimp_wr), .size_err(size_err)
  );

  function automatic logic [31:0] with_sel(input logic [31:0] base, input logic [3:0] cores);
    logic [31:0] r;
    r = base;
    for (int i = 0; i < 4; i++) if (cores[i]) r = r | (32'h8000 >> i);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " wake"}, 64'(wake_req), 64'(m_wake));
    chk({tag, " done"}, 64'(wake_done), 64'(m_done));
  endtask

  task automatic access(input logic wr, input logic [31:0] ix, input logic [63:0] d,
                        input logic [3:0] nb);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_index = ix; req_wdata = d; req_bytes = nb;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk_state("R1 reset");
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 unimp_wr", 64'(unimp_wr), 64'd0);
    chk("R1 size_err", 64'(size_err), 64'd0);
  endtask

  task automatic t_single();
    access(1'b1, with_sel(32'h83c, 4'b0100), 64'h8000_0000_0000_0000, 4'd8);
    m_wake[2] = 1'b1; m_done = 1'b1;
    chk_state("R4 single core");
    access(1'b0, 32'h82c, 64'd0, 4'd8);
    chk("R5 valid", 64'(rsp_valid), 64'd1);
    chk("R5 status done", rsp_rdata, STAT_SET);
    access(1'b0, 32'h0000_f82c, 64'd0, 4'd8);
    chk("R2 read with nibble", rsp_rdata, STAT_SET);
    @(negedge clk);
    chk("R5 valid drops", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_multi();
    access(1'b1, with_sel(32'h83c, 4'b1001), 64'h8000_0000_0000_0000, 4'd8);
    m_wake = m_wake | 4'b1001; m_done = 1'b1;
    chk_state("R4 multi set");
    access(1'b1, with_sel(32'h83c, 4'b0110), 64'h7FFF_FFFF_FFFF_FFFF, 4'd8);
    m_wake = m_wake & 4'b1001; m_done = 1'b0;
    chk_state("R3 clear other bits ignored");
    access(1'b0, 32'h82c, 64'd0, 4'd8);
    chk("R5 status clear", rsp_rdata, 64'd0);
  endtask

  task automatic t_nosel();
    access(1'b1, 32'h83c, 64'h8000_0000_0000_0000, 4'd8);
    m_done = 1'b1;
    chk_state("R3 no core selected");
    access(1'b1, with_sel(32'h83c, 4'b1111), 64'h8000_0000_0000_0000, 4'd8);
    m_wake = 4'b1111;
    chk_state("R2 full nibble");
  endtask

  task automatic t_other_rd();
    access(1'b0, 32'h83c, 64'd0, 4'd8);
    chk("R6 read wake idx", rsp_rdata, ONES);
    access(1'b0, 32'h0001_2345, 64'd0, 4'd8);
    chk("R6 read random idx", rsp_rdata, ONES);
  endtask

  task automatic t_other_wr();
    access(1'b1, with_sel(32'h82c, 4'b1111), 64'd0, 4'd8);
    chk_state("R7 write status idx");
    chk("R7 strobe", 64'(unimp_wr), 64'd1);
    @(negedge clk);
    chk("R7 strobe one cycle", 64'(unimp_wr), 64'd0);
    access(1'b1, 32'h0000_1234, 64'd0, 4'd8);
    chk_state("R7 write random idx");
  endtask

  task automatic t_size();
    access(1'b1, with_sel(32'h83c, 4'b1111), 64'd0, 4'd4);
    chk_state("R8 short write");
    chk("R8 size_err", 64'(size_err), 64'd1);
    chk("R8 no unimp", 64'(unimp_wr), 64'd0);
    @(negedge clk);
    chk("R8 strobe drops", 64'(size_err), 64'd0);
    access(1'b0, 32'h82c, 64'd0, 4'd1);
    chk("R8 short read valid", 64'(rsp_valid), 64'd1);
    chk("R8 short read data", rsp_rdata, ONES);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_nosel();
    t_other_rd();
    t_other_wr();
    t_size();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule